// File: doc/BRIEF.md
# I2C Master Start and Address Sequencer

This block drives the opening of an I2C master transaction. Software asks for a Start through a control register. The block waits until the bus is free and then pulls SDA low while SCL is high. It takes mastership and raises a start flag. It then shifts out the address byte or bytes that software writes, in 7-bit or 10-bit form. Each address step raises its own status flag. SCL is held low until software performs the access pair that retires that flag.

The SCL period comes from a runtime half-period count of system clocks. A byte takes nine SCL pulses: eight address bits, MSB first, then a ninth pulse with SDA released. On that ninth pulse the level returned by the slave is sampled. The block records whether the master will transmit or receive. It can issue a repeated Start, which a 10-bit read needs to resend the header with its read bit set. The event interrupt is the OR of the pending flags, gated by an enable bit.

The register file has four 8-bit locations, selected by `reg_addr`:

| Location | Access | Bit 0 | Bit 1 | Bit 2 | Bit 3 |
|---|---|---|---|---|---|
| 0 CTRL | read and write | go (Start request) | ten (10-bit mode) | ien (interrupt enable) | — |
| 1 DATA | write only | address byte | | | |
| 2 STAT1 | read only | sb (start sent) | adr (address done) | nack | hdr (header sent) |
| 3 STAT3 | read only | master | bus_busy level | tx (1 = transmitter) | — |

`reg_rdata` shows the selected location at all times. Only a cycle with `reg_rd` high counts as a read access. CTRL reads back its written value, except that go clears itself. DATA reads as 0. Bits not listed read as 0. `scl_half` must be at least 2.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset SCL and SDA are high, STAT1 and STAT3 read 0 and `evt_irq` is low. While CTRL go is 1 and `bus_busy` is high, no Start is made. Once `bus_busy` is low, SDA falls with SCL high, STAT3 bit 0 (master) becomes 1 and CTRL bit 0 (go) clears.
- R2: STAT1 bit 0 (sb) sets on the clock edge `scl_half`+1 edges after the edge that wrote go while in the idle state. While any of sb, hdr or adr is 1, SCL stays low.
- R3: sb clears only when a DATA write directly follows a STAT1 read, with no other access in between. A DATA write without that preceding read has no effect on the bus or on sb. The clearing write is the address byte that then goes out.
- R4: Each byte is sent MSB first over nine SCL pulses, each pulse `scl_half` cycles low and `scl_half` cycles high. SDA is released high on the ninth pulse and never rises while SCL is high. The completion flag sets exactly 18×`scl_half` edges after the DATA write edge.
- R5: In 7-bit mode (CTRL bit 1 = 0) a sent byte sets STAT1 bit 1 (adr). STAT3 bit 2 (tx) becomes the inverse of the byte's LSB.
- R6: In 10-bit mode (CTRL bit 1 = 1), a first byte of the form 11110xx0 sets STAT1 bit 3 (hdr) instead of adr, and selects transmitter. hdr clears only when a DATA write directly follows a STAT1 read. That write is the second address byte, whose completion sets adr.
- R7: adr clears only when a STAT3 read directly follows a STAT1 read. Any other access in between leaves it set.
- R8: Go set while in master mode gives a repeated Start. It waits for the byte in progress and for its flag to be cleared. Then SDA is released with SCL low, SCL rises, SDA falls, and sb sets again.
- R9: In 10-bit mode, a first byte after a Start of the form 11110xx1 sets adr directly, with hdr staying 0, and selects receiver (tx = 0).
- R10: `evt_irq` is 1 exactly when CTRL bit 2 (ien) is 1 and at least one of sb, hdr or adr is 1.
- R11: STAT1 bit 2 (nack) holds the `sda_i` level sampled at the end of the high phase of the ninth pulse of the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks a read access) |
| reg_addr | input | 2 | Register select: 0 CTRL, 1 DATA, 2 STAT1, 3 STAT3 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| scl_half | input | DIV_W | SCL half period in system clocks (at least 2) |
| bus_busy | input | 1 | High while another master owns the bus |
| sda_i | input | 1 | SDA level seen on the bus, used for the acknowledge sample |
| scl_o | output | 1 | SCL drive level (1 = released) |
| sda_o | output | 1 | SDA drive level (1 = released) |
| evt_irq | output | 1 | Event interrupt |

## Verification
All results are registered. The sb flag is due on the `scl_half`+1-th edge after the go write, and a byte's flag on the 18×`scl_half`-th edge after its DATA write. The bench reads the status one edge before and exactly on those edges. Flag clears and ignored accesses take effect on the access edge itself, so they are read back at the following falling edge through the combinational read port, without a read strobe. Bus activity is decoded by a monitor sampling on falling clock edges, and is compared in order against the Starts and bytes that the driver queued.

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [DIV_W-1:0] scl_half,
  input  logic             bus_busy,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             evt_irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_ST1  = 2'd2;
  localparam logic [1:0] A_ST3  = 2'd3;
  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WAIT, S_LO, S_HI, S_HOLD, S_RS_LO, S_RS_HI
  } st_t;

  st_t             state_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]      bit_q;
  logic [8:0]      sh_q;
  logic            go_q, ten_q, ien_q;
  logic            sb_q, hdr_q, adr_q, nack_q, msl_q, tra_q;
  logic            armed_q, kind_hdr_q;
  logic            scl_q, sda_q;

  logic wr_ctrl, wr_data, rd_s1, rd_s3, timed, tick, clr_byte, clr_adr;

  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_data  = reg_wr && reg_addr == A_DATA;
  assign rd_s1    = reg_rd && reg_addr == A_ST1;
  assign rd_s3    = reg_rd && reg_addr == A_ST3;
  assign timed    = state_q inside {S_START, S_LO, S_HI, S_RS_LO, S_RS_HI};
  assign tick     = timed && div_q == scl_half - DIV_W'(1);
  assign clr_byte = armed_q && wr_data && (sb_q || hdr_q);
  assign clr_adr  = armed_q && rd_s3 && adr_q;

  assign scl_o   = scl_q;
  assign sda_o   = sda_q;
  assign evt_irq = ien_q && (sb_q || hdr_q || adr_q);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {5'b0, ien_q, ten_q, go_q};
      A_ST1:   reg_rdata = {4'b0, hdr_q, nack_q, adr_q, sb_q};
      A_ST3:   reg_rdata = {5'b0, tra_q, bus_busy, msl_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      div_q   <= (!timed || tick) ? '0 : div_q + DIV_W'(1);
      if (rd_s1)                armed_q <= sb_q || hdr_q || adr_q;
      else if (reg_wr || reg_rd) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      bit_q      <= '0;
      sh_q       <= '1;
      go_q       <= 1'b0;
      ten_q      <= 1'b0;
      ien_q      <= 1'b0;
      sb_q       <= 1'b0;
      hdr_q      <= 1'b0;
      adr_q      <= 1'b0;
      nack_q     <= 1'b0;
      msl_q      <= 1'b0;
      tra_q      <= 1'b0;
      kind_hdr_q <= 1'b0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      case (state_q)
        S_IDLE: if (go_q && !bus_busy) begin
          state_q <= S_START;
          sda_q   <= 1'b0;
          msl_q   <= 1'b1;
          go_q    <= 1'b0;
        end
        S_START: if (tick) begin
          state_q <= S_WAIT;
          scl_q   <= 1'b0;
          sb_q    <= 1'b1;
        end
        S_WAIT: begin
          if (clr_byte) begin
            sh_q    <= {reg_wdata, 1'b1};
            bit_q   <= '0;
            state_q <= S_LO;
            if (sb_q) begin
              sb_q       <= 1'b0;
              tra_q      <= ~reg_wdata[0];
              kind_hdr_q <= ten_q && reg_wdata[7:3] == 5'b11110 && !reg_wdata[0];
            end else begin
              hdr_q      <= 1'b0;
              kind_hdr_q <= 1'b0;
            end
          end else if (clr_adr) begin
            adr_q   <= 1'b0;
            state_q <= S_HOLD;
          end
        end
        S_LO: begin
          sda_q <= sh_q[8];
          if (tick) begin
            state_q <= S_HI;
            scl_q   <= 1'b1;
          end
        end
        S_HI: if (tick) begin
          scl_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            nack_q  <= sda_i;
            state_q <= S_WAIT;
            if (kind_hdr_q) hdr_q <= 1'b1;
            else            adr_q <= 1'b1;
          end else begin
            bit_q   <= bit_q + 4'd1;
            sh_q    <= {sh_q[7:0], 1'b0};
            state_q <= S_LO;
          end
        end
        S_HOLD: if (go_q) begin
          state_q <= S_RS_LO;
          go_q    <= 1'b0;
          sda_q   <= 1'b1;
        end
        S_RS_LO: if (tick) begin
          state_q <= S_RS_HI;
          scl_q   <= 1'b1;
        end
        S_RS_HI: if (tick) begin
          state_q <= S_START;
          sda_q   <= 1'b0;
        end
        default: state_q <= S_IDLE;
      endcase
      if (wr_ctrl) begin
        go_q  <= reg_wdata[0];
        ten_q <= reg_wdata[1];
        ien_q <= reg_wdata[2];
      end
    end
  end
endmodule

module i2c_addr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_o,
  input logic       sda_o,
  input logic       sb,
  input logic       hdr,
  input logic       adr,
  input logic       msl,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       bus_busy
);
  a_r4_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o)) |-> !$rose(sda_o));

  a_r2_scl_low_while_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sb || hdr || adr) |-> !scl_o);

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sb, hdr, adr}));

  a_r3_sb_clear_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb) |-> $past(reg_wr && reg_addr == 2'd1));

  a_r7_adr_clear_on_stat3_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adr) |-> $past(reg_rd && reg_addr == 2'd3));

  a_r1_master_needs_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msl) |-> $past(!bus_busy));
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o),
  .sb(sb_q), .hdr(hdr_q), .adr(adr_q), .msl(msl_q),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .bus_busy(bus_busy)
);

// File: tb/test_i2c_addr_seq.sv
`timescale 1ns/100ps
module test_i2c_addr_seq;
  localparam int H = 4;
  localparam logic [1:0] CTRL = 2'd0, DATA = 2'd1, ST1 = 2'd2, ST3 = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [7:0] scl_half = 8'(H);
  logic bus_busy = 1'b0, ack_lvl = 1'b0;
  logic scl_o, sda_o, evt_irq;

  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  int mbits = 0;
  logic [8:0] mshift = '0;
  logic pscl = 1'b1, psda = 1'b1;

  always #2.5 clk = ~clk;

  i2c_addr_seq i_i2c_addr_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_half(scl_half), .bus_busy(bus_busy), .sda_i(ack_lvl),
    .scl_o(scl_o), .sda_o(sda_o), .evt_irq(evt_irq));

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic void observe(logic [9:0] item);
    if (exp_q.size() == 0) chk(1'b0, "R4 unexpected bus item", int'(item), 0);
    else begin
      logic [9:0] e;
      e = exp_q.pop_front();
      chk(item == e, "R4 bus item", int'(item), int'(e));
    end
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mbits = 0; pscl = 1'b1; psda = 1'b1;
    end else begin
      if (scl_o && pscl && psda && !sda_o) begin
        observe(10'h200);
        mbits = 0;
      end else if (scl_o && !pscl) begin
        mshift = {mshift[7:0], sda_o};
        mbits++;
        if (mbits == 9) begin
          observe({1'b0, mshift});
          mbits = 0;
        end
      end
      pscl = scl_o; psda = sda_o;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.1;
    v = reg_rdata;
  endtask

  task automatic exp_start();
    exp_q.push_back(10'h200);
  endtask

  task automatic exp_byte(input logic [7:0] b);
    exp_q.push_back({1'b0, b, 1'b1});
  endtask

  task automatic wait_flag(input logic [7:0] mask, input string tag);
    logic [7:0] v;
    bit seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      peek(ST1, v);
      seen = (v & mask) != 0;
    end
    chk(seen, tag, 0, int'(mask));
    @(negedge clk);
  endtask

  task automatic do_reset();
    chk(exp_q.size() == 0, "R4 all expected items seen", exp_q.size(), 0);
    exp_q.delete();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(scl_o && sda_o, "R1 lines released after reset", {scl_o, sda_o}, 3);
    peek(ST1, v); chk(v == 8'h00, "R1 STAT1 reset", v, 0);
    peek(ST3, v); chk(v == 8'h00, "R1 STAT3 reset", v, 0);
    chk(!evt_irq, "R1 irq reset", evt_irq, 0);
    @(negedge clk);

    // R1 busy bus blocks Start
    bus_busy = 1'b1;
    wr(CTRL, 8'h05);
    repeat (30) @(negedge clk);
    chk(sda_o && scl_o, "R1 no Start while busy", {scl_o, sda_o}, 3);
    peek(ST3, v); chk(v[0] == 1'b0, "R1 not master while busy", v[0], 0);
    @(negedge clk);
    exp_start();
    bus_busy = 1'b0;
    wait_flag(8'h01, "R1 sb after bus free");
    peek(ST3, v); chk(v[0] == 1'b1, "R1 master bit", v[0], 1);
    peek(CTRL, v); chk(v[0] == 1'b0, "R1 go self-clears", v[0], 0);
    chk(evt_irq, "R10 irq with sb and ien", evt_irq, 1);
    @(negedge clk);

    // R3 ignored clears
    wr(DATA, 8'h55);
    repeat (3 * H) @(negedge clk);
    peek(ST1, v); chk(v[0] == 1'b1, "R3 sb kept on bare DATA write", v[0], 1);
    chk(!scl_o, "R2 SCL held low while sb", scl_o, 0);
    @(negedge clk);
    rd(ST1); rd(CTRL); wr(DATA, 8'h55);
    repeat (3 * H) @(negedge clk);
    peek(ST1, v); chk(v[0] == 1'b1, "R3 sb kept when sequence broken", v[0], 1);
    @(negedge clk);

    // R3/R4/R5 proper clear, 7-bit write
    rd(ST1);
    exp_byte(8'hA4);
    wr(DATA, 8'hA4);
    peek(ST1, v); chk(v[0] == 1'b0, "R3 sb cleared by STAT1 read then DATA write", v[0], 0);
    repeat (18 * H - 1) @(negedge clk);
    peek(ST1, v); chk(v[1] == 1'b0, "R4 adr not yet set one edge early", v[1], 0);
    @(negedge clk);
    peek(ST1, v); chk(v[1] == 1'b1, "R4 adr set at 18*H edges", v[1], 1);
    chk(v[2] == 1'b0, "R11 nack clear with ACK low", v[2], 0);
    peek(ST3, v); chk(v[2] == 1'b1, "R5 tx for LSB 0", v[2], 1);
    chk(evt_irq, "R10 irq with adr", evt_irq, 1);
    @(negedge clk);

    // R7 address flag clearing
    rd(ST3);
    peek(ST1, v); chk(v[1] == 1'b1, "R7 adr kept on bare STAT3 read", v[1], 1);
    @(negedge clk);
    rd(ST1); wr(CTRL, 8'h04); rd(ST3);
    peek(ST1, v); chk(v[1] == 1'b1, "R7 adr kept when sequence broken", v[1], 1);
    @(negedge clk);
    rd(ST1); rd(ST3);
    peek(ST1, v); chk(v[1] == 1'b0, "R7 adr cleared", v[1], 0);
    chk(!evt_irq, "R10 irq low with no flag", evt_irq, 0);
    @(negedge clk);

    // Scenario 2: 7-bit read, irq disabled, sb timing, nack, mid-byte repeated Start
    do_reset();
    ack_lvl = 1'b1;
    exp_start();
    wr(CTRL, 8'h01);
    repeat (H) @(negedge clk);
    peek(ST1, v); chk(v[0] == 1'b0, "R2 sb not set one edge early", v[0], 0);
    @(negedge clk);
    peek(ST1, v); chk(v[0] == 1'b1, "R2 sb set at H+1 edges", v[0], 1);
    chk(!evt_irq, "R10 irq masked when ien 0", evt_irq, 0);
    chk(!scl_o && !sda_o, "R2 lines low after Start", {scl_o, sda_o}, 0);
    @(negedge clk);
    rd(ST1);
    exp_byte(8'h4B);
    wr(DATA, 8'h4B);
    repeat (5) @(negedge clk);
    wr(CTRL, 8'h01);
    wait_flag(8'h02, "R5 adr after read address");
    peek(ST3, v); chk(v[2] == 1'b0, "R5 rx for LSB 1", v[2], 0);
    peek(ST1, v); chk(v[2] == 1'b1, "R11 nack set with ACK high", v[2], 1);
    @(negedge clk);
    repeat (4 * H) @(negedge clk);
    peek(ST1, v); chk(v == 8'h06, "R8 no repeated Start while adr pending", v, 6);
    @(negedge clk);
    exp_start();
    rd(ST1); rd(ST3);
    wait_flag(8'h01, "R8 sb after repeated Start");
    peek(ST3, v); chk(v[0] == 1'b1, "R8 still master", v[0], 1);
    @(negedge clk);

    // Scenario 3: 10-bit write then 10-bit read
    do_reset();
    ack_lvl = 1'b0;
    exp_start();
    wr(CTRL, 8'h07);
    wait_flag(8'h01, "R6 sb in 10-bit mode");
    rd(ST1);
    exp_byte(8'hF2);
    wr(DATA, 8'hF2);
    wait_flag(8'h08, "R6 hdr after header");
    peek(ST1, v); chk(v[1] == 1'b0, "R6 adr not set by header", v[1], 0);
    chk(evt_irq, "R10 irq with hdr", evt_irq, 1);
    @(negedge clk);
    wr(DATA, 8'h3C);
    repeat (3 * H) @(negedge clk);
    peek(ST1, v); chk(v[3] == 1'b1, "R6 hdr kept on bare DATA write", v[3], 1);
    @(negedge clk);
    rd(ST1);
    exp_byte(8'h3C);
    wr(DATA, 8'h3C);
    peek(ST1, v); chk(v[3] == 1'b0, "R6 hdr cleared", v[3], 0);
    wait_flag(8'h02, "R6 adr after second byte");
    peek(ST3, v); chk(v[2] == 1'b1, "R6 transmitter after 11110xx0", v[2], 1);
    @(negedge clk);
    rd(ST1); rd(ST3);
    exp_start();
    wr(CTRL, 8'h03);
    wait_flag(8'h01, "R8 sb after repeated Start in 10-bit");
    rd(ST1);
    exp_byte(8'hF3);
    wr(DATA, 8'hF3);
    repeat (18 * H) @(negedge clk);
    peek(ST1, v); chk(v[1] == 1'b1 && v[3] == 1'b0, "R9 read header sets adr only", v, 2);
    peek(ST3, v); chk(v[2] == 1'b0, "R9 receiver after 11110xx1", v[2], 0);
    @(negedge clk);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected items seen", exp_q.size(), 0);
    finish_run();
  end
endmodule